// File: doc/BRIEF.md
# Precise Exception Capture and PC Steering Unit

This block sits beside an in-order pipeline and owns the architectural exception state. Three pipeline stages can each flag a fault together with the PC of the faulting instruction: the fetch stage, the execute ALU and the data-memory stage. Each flag is a single bit that the stage computes from the same operands as its own operation. When a fault is accepted, the block records it in a sticky per-source status bit and saves the faulting PC. In the following cycle it pulses a squash to kill every younger instruction still in flight, and it pulses a redirect whose target is the handler vector for that fault type.

A return-from-exception instruction, signalled when it retires, clears all status bits. It redirects the PC back to the saved exception PC and squashes the instructions behind it. When several stages fault together, the oldest instruction wins. Requests that arrive while the squash pulse is out come from instructions being killed, so the block ignores them.

Top module: `trap_ctrl`

## Requirements
- R1: After synchronous reset the status bits and the saved exception PC are zero, and neither squash nor redirect is asserted.
- R2: A single accepted fault sets its status bit one cycle later and loads the saved exception PC with that request's PC. The status bits are bit 0 for fetch, bit 1 for ALU and bit 2 for data memory.
- R3: When several faults are requested in one cycle, data memory wins over ALU and ALU wins over fetch. Only the winner's status bit is set and only the winner's PC is saved.
- R4: An accepted fault or return produces a squash pulse exactly one cycle long in the cycle after acceptance.
- R5: The redirect is valid in exactly the cycles in which squash is high. For a fault, the target is HANDLER_BASE + 0x00 for fetch, + 0x10 for ALU and + 0x20 for data memory.
- R6: Status bits are sticky: a later fault ORs its bit into those already set, and the bits stay set until a return.
- R7: An accepted return clears all three status bits, leaves the saved PC unchanged, and redirects to the saved PC as it stood at the return.
- R8: A return and faults in the same cycle: the return takes effect and the faults are ignored.
- R9: Any fault or return request presented while squash is high is ignored: status, saved PC and redirect are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_flt_i | input | 1 | Fetch-stage fault flag |
| fetch_flt_pc_i | input | PC_W | PC of the fetch-stage instruction |
| alu_flt_i | input | 1 | ALU fault flag |
| alu_flt_pc_i | input | PC_W | PC of the execute-stage instruction |
| mem_flt_i | input | 1 | Data-memory fault flag |
| mem_flt_pc_i | input | PC_W | PC of the memory-stage instruction |
| ret_i | input | 1 | Return-from-exception retiring |
| status_o | output | 3 | Sticky status bits: [0] fetch, [1] ALU, [2] data memory |
| epc_o | output | PC_W | Saved exception PC |
| squash_o | output | 1 | One-cycle kill of younger instructions |
| redirect_vld_o | output | 1 | One-cycle PC redirect strobe |
| redirect_pc_o | output | PC_W | Redirect target address |

## Verification
The hardest situation to reach is a request that lands exactly in the squash cycle. That request has to be discarded, while one arriving a cycle later has to be accepted. The bench sweeps all sixteen combinations of return and three fault flags, starting from a preset status. It drives every request line high during each resulting squash cycle and checks that nothing moved. A clean request then follows in the next cycle.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int N_SRC = 3;

    // Index order is age order: a higher index is an older pipeline stage.
    typedef enum logic [1:0] {
        SRC_FETCH = 2'd0,
        SRC_ALU   = 2'd1,
        SRC_MEM   = 2'd2
    } flt_src_e;

    localparam int VEC_STRIDE = 16;

    function automatic logic [63:0] vector_of(input logic [63:0] base, input flt_src_e src);
        return base + 64'(VEC_STRIDE) * 64'(src);
    endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic [N_SRC-1:0]           req_vld,
    input  logic [N_SRC-1:0][PC_W-1:0] req_pc,
    input  logic                       block,
    output logic                       take,
    output flt_src_e                   win_src,
    output logic [PC_W-1:0]            win_pc
);
    always_comb begin
        take    = 1'b0;
        win_src = SRC_FETCH;
        win_pc  = '0;
        // Later (older) indices overwrite earlier ones.
        for (int i = 0; i < N_SRC; i++) begin
            if (req_vld[i] && !block) begin
                take    = 1'b1;
                win_src = flt_src_e'(i);
                win_pc  = req_pc[i];
            end
        end
    end
endmodule

// File: rtl/trap_state.sv
module trap_state
    import trap_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  flt_src_e         win_src,
    input  logic [PC_W-1:0]  win_pc,
    input  logic             clear,
    output logic [N_SRC-1:0] status,
    output logic [PC_W-1:0]  epc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            epc    <= '0;
        end else if (clear) begin
            status <= '0;
        end else if (take) begin
            status[win_src] <= 1'b1;
            epc             <= win_pc;
        end
    end
endmodule

// File: rtl/trap_steer.sv
module trap_steer
    import trap_pkg::*;
#(
    parameter int          PC_W         = 32,
    parameter logic [63:0] HANDLER_BASE = 64'h1000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  flt_src_e        win_src,
    input  logic            ret_take,
    input  logic [PC_W-1:0] epc,
    output logic            squash,
    output logic            redir_vld,
    output logic [PC_W-1:0] redir_pc
);
    logic [PC_W-1:0] target;

    always_comb begin
        if (ret_take) target = epc;
        else          target = PC_W'(vector_of(HANDLER_BASE, win_src));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            squash    <= 1'b0;
            redir_vld <= 1'b0;
            redir_pc  <= '0;
        end else begin
            squash    <= take || ret_take;
            redir_vld <= take || ret_take;
            if (take || ret_take) redir_pc <= target;
        end
    end
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_pkg::*;
#(
    parameter int          PC_W         = 32,
    parameter logic [63:0] HANDLER_BASE = 64'h1000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fetch_flt_i,
    input  logic [PC_W-1:0] fetch_flt_pc_i,
    input  logic            alu_flt_i,
    input  logic [PC_W-1:0] alu_flt_pc_i,
    input  logic            mem_flt_i,
    input  logic [PC_W-1:0] mem_flt_pc_i,
    input  logic            ret_i,
    output logic [2:0]      status_o,
    output logic [PC_W-1:0] epc_o,
    output logic            squash_o,
    output logic            redirect_vld_o,
    output logic [PC_W-1:0] redirect_pc_o
);
    logic [N_SRC-1:0]           req_vld;
    logic [N_SRC-1:0][PC_W-1:0] req_pc;
    logic                       live;
    logic                       ret_take;
    logic                       take;
    flt_src_e                   win_src;
    logic [PC_W-1:0]            win_pc;
    logic [N_SRC-1:0]           status;
    logic [PC_W-1:0]            epc;

    assign req_vld  = {mem_flt_i, alu_flt_i, fetch_flt_i};
    assign req_pc   = {mem_flt_pc_i, alu_flt_pc_i, fetch_flt_pc_i};
    assign live     = !squash_o;
    assign ret_take = ret_i && live;

    trap_arbiter #(.PC_W(PC_W)) u_arb (
        .req_vld (req_vld),
        .req_pc  (req_pc),
        .block   (!live || ret_i),
        .take    (take),
        .win_src (win_src),
        .win_pc  (win_pc)
    );

    trap_state #(.PC_W(PC_W)) u_state (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .win_src (win_src),
        .win_pc  (win_pc),
        .clear   (ret_take),
        .status  (status),
        .epc     (epc)
    );

    trap_steer #(.PC_W(PC_W), .HANDLER_BASE(HANDLER_BASE)) u_steer (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .win_src   (win_src),
        .ret_take  (ret_take),
        .epc       (epc),
        .squash    (squash_o),
        .redir_vld (redirect_vld_o),
        .redir_pc  (redirect_pc_o)
    );

    assign status_o = status;
    assign epc_o    = epc;
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk
    import trap_pkg::*;
#(
    parameter int          PC_W         = 32,
    parameter logic [63:0] HANDLER_BASE = 64'h1000
) (
    input logic            clk,
    input logic            rst,
    input logic            fetch_flt_i,
    input logic            alu_flt_i,
    input logic            mem_flt_i,
    input logic [PC_W-1:0] mem_flt_pc_i,
    input logic            ret_i,
    input logic [2:0]      status_o,
    input logic [PC_W-1:0] epc_o,
    input logic            squash_o,
    input logic            redirect_vld_o,
    input logic [PC_W-1:0] redirect_pc_o
);
    a_r4_squash_one_cycle: assert property (@(posedge clk) disable iff (rst)
        squash_o |=> !squash_o);

    a_r5_redirect_matches_squash: assert property (@(posedge clk) disable iff (rst)
        redirect_vld_o == squash_o);

    a_r2_mem_fault_saves_pc: assert property (@(posedge clk) disable iff (rst)
        (mem_flt_i && !ret_i && !squash_o) |=> (epc_o == $past(mem_flt_pc_i)) && status_o[2]);

    a_r5_mem_vector: assert property (@(posedge clk) disable iff (rst)
        (mem_flt_i && !ret_i && !squash_o) |=>
            (redirect_pc_o == PC_W'(vector_of(HANDLER_BASE, SRC_MEM))));

    a_r7_return_clears: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !squash_o) |=> (status_o == 3'b000) && redirect_vld_o
            && (redirect_pc_o == $past(epc_o)) && $stable(epc_o));

    a_r9_ignored_in_squash: assert property (@(posedge clk) disable iff (rst)
        squash_o |=> $stable(status_o) && $stable(epc_o) && !redirect_vld_o);

    a_r6_sticky_without_return: assert property (@(posedge clk) disable iff (rst)
        !ret_i |=> ((status_o & $past(status_o)) == $past(status_o)));
endmodule

bind trap_ctrl trap_ctrl_chk #(.PC_W(PC_W), .HANDLER_BASE(HANDLER_BASE)) i_chk (
    .clk            (clk),
    .rst            (rst),
    .fetch_flt_i    (fetch_flt_i),
    .alu_flt_i      (alu_flt_i),
    .mem_flt_i      (mem_flt_i),
    .mem_flt_pc_i   (mem_flt_pc_i),
    .ret_i          (ret_i),
    .status_o       (status_o),
    .epc_o          (epc_o),
    .squash_o       (squash_o),
    .redirect_vld_o (redirect_vld_o),
    .redirect_pc_o  (redirect_pc_o)
);

// File: tb/test_trap_ctrl.sv
module test_trap_ctrl;
    localparam int          PC_W = 32;
    localparam logic [63:0] BASE = 64'h1000;

    logic            clk = 1'b0;
    logic            rst;
    logic            fetch_flt_i, alu_flt_i, mem_flt_i, ret_i;
    logic [PC_W-1:0] fetch_flt_pc_i, alu_flt_pc_i, mem_flt_pc_i;
    logic [2:0]      status_o;
    logic [PC_W-1:0] epc_o;
    logic            squash_o, redirect_vld_o;
    logic [PC_W-1:0] redirect_pc_o;

    int checks = 0;
    int errors = 0;
    logic [2:0]      m_status;
    logic [PC_W-1:0] m_epc;

    always #5 clk = ~clk;

    trap_ctrl #(.PC_W(PC_W), .HANDLER_BASE(BASE)) i_trap_ctrl (
        .clk(clk), .rst(rst),
        .fetch_flt_i(fetch_flt_i), .fetch_flt_pc_i(fetch_flt_pc_i),
        .alu_flt_i(alu_flt_i), .alu_flt_pc_i(alu_flt_pc_i),
        .mem_flt_i(mem_flt_i), .mem_flt_pc_i(mem_flt_pc_i),
        .ret_i(ret_i),
        .status_o(status_o), .epc_o(epc_o), .squash_o(squash_o),
        .redirect_vld_o(redirect_vld_o), .redirect_pc_o(redirect_pc_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        {fetch_flt_i, alu_flt_i, mem_flt_i, ret_i} = 4'b0;
    endtask

    // Drive one request pattern, check the pulse cycle, then flood the
    // squash cycle with requests and check nothing is taken.
    task automatic apply(input logic r, input logic m, input logic a, input logic f,
                         input logic [PC_W-1:0] seed);
        logic            pulse;
        logic [PC_W-1:0] tgt;
        ret_i = r; mem_flt_i = m; alu_flt_i = a; fetch_flt_i = f;
        fetch_flt_pc_i = seed + 32'h100;
        alu_flt_pc_i   = seed + 32'h200;
        mem_flt_pc_i   = seed + 32'h300;
        pulse = r | m | a | f;
        tgt = '0;
        if (r) begin
            tgt = m_epc;          // R8: faults ignored alongside a return
            m_status = 3'b000;
        end else if (m) begin
            tgt = PC_W'(BASE + 64'h20); m_status[2] = 1'b1; m_epc = mem_flt_pc_i;
        end else if (a) begin
            tgt = PC_W'(BASE + 64'h10); m_status[1] = 1'b1; m_epc = alu_flt_pc_i;
        end else if (f) begin
            tgt = PC_W'(BASE);          m_status[0] = 1'b1; m_epc = fetch_flt_pc_i;
        end
        @(negedge clk);
        check("R2/R3/R6/R7/R8 status", 64'(status_o), 64'(m_status));
        check("R2/R3 epc", 64'(epc_o), 64'(m_epc));
        check("R4 squash", 64'(squash_o), 64'(pulse));
        check("R5 redirect valid", 64'(redirect_vld_o), 64'(pulse));
        if (pulse) begin
            check("R5/R7 redirect target", 64'(redirect_pc_o), 64'(tgt));
            // R9: everything asserted during the squash cycle
            {fetch_flt_i, alu_flt_i, mem_flt_i, ret_i} = 4'b1111;
            fetch_flt_pc_i = 32'hDEAD_0000; alu_flt_pc_i = 32'hDEAD_1000;
            mem_flt_pc_i = 32'hDEAD_2000;
            @(negedge clk);
            check("R9 status held", 64'(status_o), 64'(m_status));
            check("R9 epc held", 64'(epc_o), 64'(m_epc));
            check("R4/R9 squash dropped", 64'(squash_o), 64'd0);
            check("R9 no redirect", 64'(redirect_vld_o), 64'd0);
        end
        idle();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        fetch_flt_pc_i = '0; alu_flt_pc_i = '0; mem_flt_pc_i = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_status = 3'b000;
        m_epc = '0;
        // R1: reset state
        check("R1 status", 64'(status_o), 64'd0);
        check("R1 epc", 64'(epc_o), 64'd0);
        check("R1 squash", 64'(squash_o), 64'd0);
        check("R1 redirect", 64'(redirect_vld_o), 64'd0);

        // Exhaustive sweep over {ret, mem, alu, fetch}, each from two preset states
        for (int pass = 0; pass < 2; pass++) begin
            for (int c = 0; c < 16; c++) begin
                // Preset: R6 sticky accumulation before the pattern under test
                apply(1'b0, 1'b0, 1'b0, 1'b1, 32'h4000 + 32'(c) * 32'h10);
                if (pass == 1) apply(1'b0, 1'b0, 1'b1, 1'b0, 32'h8000 + 32'(c) * 32'h10);
                apply(c[3], c[2], c[1], c[0], 32'h10000 * 32'(c + 1) + 32'(pass));
                // A clean return right after, R7
                apply(1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule